// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a simple synchronous request bus and one external asynchronous static RAM of 262,144 sixteen-bit words. A requester offers a read or a write with an 18-bit word address, 16 bits of write data and two byte-lane enables. The controller then produces the memory's active-low select, write, output and per-byte strobes, and it drives or releases a shared tristate data bus. Each phase of an access lasts a whole number of clock periods, and parameters set those counts so that the access time of the memory's speed grade is met.

Read data is registered at the end of the access window and comes back with a one-cycle valid pulse. The controller drops its ready signal for the length of each access. After a read it always adds a turnaround cycle with the memory's outputs off. After the write strobe rises it holds address and data for a set number of cycles before it lets go of the bus. A request whose byte enables are both clear never reaches the memory.

Top module: `sram_byte_ctrl`

## Requirements
- R1: After reset and whenever no access is in progress, memCsN, memWeN, memOeN, memUbN and memLbN are all 1, memData is not driven by the controller, and reqReady is 1.
- R2: A request is taken on a rising clock edge where reqValid and reqReady are both 1. From the next cycle, reqReady stays 0 until the access, including its turnaround or hold cycles, has finished.
- R3: A read with at least one byte enable set holds memCsN=0, memOeN=0, memWeN=1 and memAddr equal to the request address for RD_CYC cycles. During those cycles memLbN is the inverse of reqByteEn[0] and memUbN is the inverse of reqByteEn[1].
- R4: Read data is sampled on the clock edge that ends the read window. rspValid is 1 for exactly the following cycle. rspData holds the memory's bits 7:0 and 15:8 for enabled lanes and zero for disabled lanes.
- R5: Every read is followed by one turnaround cycle with all memory strobes at 1 and the bus undriven before reqReady returns to 1. A write can therefore never follow a read without an output-enable-high gap.
- R6: A write with at least one byte enable set holds memCsN=0, memWeN=0, memOeN=1, the request address and the lane strobes for WR_CYC cycles. During those cycles the controller drives the write data on enabled lanes and leaves disabled lanes at high impedance.
- R7: After memWeN rises, the controller keeps memCsN=0, memOeN=1, the same address, the same lane strobes and the same driven data for HOLD_CYC cycles. It then releases the bus and returns to idle.
- R8: The controller drives memData only while memOeN is 1, and never on a lane whose strobe is inactive.
- R9: Byte enable bit 0 governs data bits 7:0 and bit 1 governs bits 15:8. A single-lane write leaves the other byte of the word unchanged.
- R10: A request with both byte enables 0 touches no memory strobe and keeps reqReady at 1. As a write it changes nothing. As a read it returns rspValid=1 with rspData=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Controller can take a request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 18 | Word address |
| reqWdata | input | 16 | Write data |
| reqByteEn | input | 2 | Lane enables, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rspValid | output | 1 | Read data valid pulse |
| rspData | output | 16 | Read data |
| memAddr | output | 18 | Memory address |
| memCsN | output | 1 | Memory chip select, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memUbN | output | 1 | Upper byte strobe, active low |
| memLbN | output | 1 | Lower byte strobe, active low |
| memData | inout | 16 | Shared data bus |

## Verification
The bench attacks three kinds of mistake.

**Read directly followed by write.** This is offered with no idle gap. A controller that skips the turnaround would start driving while output enable is still falling, which shows up as a strobe or bus mismatch in that cycle.

**Single-lane accesses and zero-lane requests.** A mixed-up lane mapping would corrupt the untouched byte, and a read would return garbage on a disabled lane. A zero-lane request that leaks through would pulse the strobes, or would fail to return its zero response.

**Timing of the write strobe's rising edge and the cycles after it.** The memory model in the bench latches data only on that edge. Releasing the bus or moving the address too early would therefore store the wrong word, and the later read-back would expose it.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WRITE,
    ST_HOLD
  } ctlState_e;

  // Registered memory-side control levels
  typedef struct packed {
    logic csN;
    logic weN;
    logic oeN;
    logic laneOn;
    logic drvEn;
  } pinCtl_t;

  // Strobes from control to datapath
  typedef struct packed {
    pinCtl_t pin;
    logic    load;
    logic    capture;
    logic    zeroRsp;
  } sramStrb_t;

  function automatic pinCtl_t decodePins(ctlState_e s);
    pinCtl_t p;
    p.csN    = !(s == ST_READ || s == ST_WRITE || s == ST_HOLD);
    p.weN    = (s != ST_WRITE);
    p.oeN    = (s != ST_READ);
    p.laneOn = (s == ST_READ || s == ST_WRITE || s == ST_HOLD);
    p.drvEn  = (s == ST_WRITE || s == ST_HOLD);
    return p;
  endfunction

endpackage

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int RD_CYC   = 6,
  parameter int WR_CYC   = 6,
  parameter int HOLD_CYC = 1
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      beAny,
  output logic      reqReady,
  output sramStrb_t strb
);

  localparam int MAX_CYC = (RD_CYC > WR_CYC) ? ((RD_CYC > HOLD_CYC) ? RD_CYC : HOLD_CYC)
                                             : ((WR_CYC > HOLD_CYC) ? WR_CYC : HOLD_CYC);
  localparam int CNT_W = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] RD_LAST   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WR_LAST   = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

  ctlState_e        state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  pinCtl_t          pinQ;
  logic             accept;

  assign reqReady = (state == ST_IDLE);
  assign accept   = reqValid && reqReady;

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    unique case (state)
      ST_IDLE: begin
        if (accept && beAny) begin
          nextState = reqWrite ? ST_WRITE : ST_READ;
          nextCnt   = '0;
        end
      end
      ST_READ: begin
        if (cnt == RD_LAST) begin
          nextState = ST_TURN;
          nextCnt   = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_TURN: begin
        nextState = ST_IDLE;
        nextCnt   = '0;
      end
      ST_WRITE: begin
        if (cnt == WR_LAST) begin
          nextState = ST_HOLD;
          nextCnt   = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      ST_HOLD: begin
        if (cnt == HOLD_LAST) begin
          nextState = ST_IDLE;
          nextCnt   = '0;
        end else begin
          nextCnt = cnt + 1'b1;
        end
      end
      default: begin
        nextState = ST_IDLE;
        nextCnt   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      pinQ  <= decodePins(ST_IDLE);
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      pinQ  <= decodePins(nextState);
    end
  end

  always_comb begin
    strb.pin     = pinQ;
    strb.load    = accept;
    strb.capture = (state == ST_READ) && (cnt == RD_LAST);
    strb.zeroRsp = accept && !beAny && !reqWrite;
  end

  // R1: ready implies memory in standby
  assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (pinQ.csN && pinQ.weN && pinQ.oeN && !pinQ.drvEn));

  // R2: a real access drops ready next cycle
  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && beAny) |=> !reqReady);

  // R5: when output enable turns off the controller is still busy and deselected
  assert_turn_after_read_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pinQ.oeN) |-> (pinQ.csN && !reqReady && !pinQ.drvEn));

  // R6: write strobe and output enable never both active
  assert_we_oe_excl_R6: assert property (@(posedge clk) disable iff (!rstN)
    !pinQ.weN |-> pinQ.oeN);

endmodule

// File: rtl/sramc_datapath.sv
module sramc_datapath
  import sramc_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int LANES  = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  sramStrb_t            strb,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [LANES*8-1:0]   reqWdata,
  input  logic [LANES-1:0]     reqByteEn,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [LANES-1:0]     memBeN,
  inout  wire  [LANES*8-1:0]   memData,
  output logic                 rspValid,
  output logic [LANES*8-1:0]   rspData
);

  localparam int DATA_W = LANES * 8;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] capWord;
  logic [LANES-1:0]  drvOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      beQ   <= '0;
    end else if (strb.load) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
      beQ   <= reqByteEn;
    end
  end

  assign memAddr = addrQ;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign memBeN[i]        = !(strb.pin.laneOn && beQ[i]);
    assign drvOn[i]         = strb.pin.drvEn && beQ[i];
    assign memData[i*8 +: 8] = drvOn[i] ? dataQ[i*8 +: 8] : 8'hzz;
    assign capWord[i*8 +: 8] = beQ[i] ? memData[i*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= strb.capture || strb.zeroRsp;
      if (strb.capture) begin
        rspData <= capWord;
      end else if (strb.zeroRsp) begin
        rspData <= '0;
      end
    end
  end

  // R8: bus driven only with memory outputs off and lane strobe active
  assert_drive_oe_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (|drvOn) |-> (strb.pin.oeN && ((drvOn & memBeN) == '0)));

  // R4: capture edge yields a response next cycle
  assert_capture_rsp_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.capture |=> rspValid);

  // R7: address and data unchanged across write strobe rise, bus still driven
  assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(strb.pin.weN) |-> ($stable(addrQ) && $stable(dataQ) && strb.pin.drvEn));

endmodule

// File: rtl/sram_byte_ctrl.sv
module sram_byte_ctrl
  import sramc_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int RD_CYC   = 6,
  parameter int WR_CYC   = 6,
  parameter int HOLD_CYC = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic [1:0]        reqByteEn,
  output logic              rspValid,
  output logic [15:0]       rspData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memUbN,
  output logic              memLbN,
  inout  wire  [15:0]       memData
);

  localparam int LANES = 2;

  sramStrb_t        strb;
  logic [LANES-1:0] laneN;

  sramc_ctrl #(
    .RD_CYC  (RD_CYC),
    .WR_CYC  (WR_CYC),
    .HOLD_CYC(HOLD_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .beAny   (|reqByteEn),
    .reqReady(reqReady),
    .strb    (strb)
  );

  sramc_datapath #(
    .ADDR_W(ADDR_W),
    .LANES (LANES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqByteEn(reqByteEn),
    .memAddr  (memAddr),
    .memBeN   (laneN),
    .memData  (memData),
    .rspValid (rspValid),
    .rspData  (rspData)
  );

  assign memCsN = strb.pin.csN;
  assign memWeN = strb.pin.weN;
  assign memOeN = strb.pin.oeN;
  assign memLbN = laneN[0];
  assign memUbN = laneN[1];

endmodule

// File: tb/sram_byte_ctrl_test.sv
module sram_byte_ctrl_test;

  localparam int RD  = 4;
  localparam int WR  = 3;
  localparam int HLD = 2;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqReady;
  logic        reqWrite;
  logic [17:0] reqAddr;
  logic [15:0] reqWdata;
  logic [1:0]  reqByteEn;
  logic        rspValid;
  logic [15:0] rspData;
  logic [17:0] memAddr;
  logic        memCsN, memWeN, memOeN, memUbN, memLbN;
  wire  [15:0] memData;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sram_byte_ctrl #(
    .ADDR_W(18), .RD_CYC(RD), .WR_CYC(WR), .HOLD_CYC(HLD)
  ) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqByteEn(reqByteEn), .rspValid(rspValid), .rspData(rspData),
    .memAddr(memAddr), .memCsN(memCsN), .memWeN(memWeN), .memOeN(memOeN),
    .memUbN(memUbN), .memLbN(memLbN), .memData(memData)
  );

  // Behavioural asynchronous memory (low 8 address bits select the word)
  logic [15:0] physMem [0:255];
  logic [15:0] expMem  [0:255];

  assign memData[7:0]  = (!memCsN && !memOeN && memWeN && !memLbN) ? physMem[memAddr[7:0]][7:0]  : 8'hzz;
  assign memData[15:8] = (!memCsN && !memOeN && memWeN && !memUbN) ? physMem[memAddr[7:0]][15:8] : 8'hzz;

  always @(posedge memWeN) begin
    if (memCsN === 1'b0) begin
      if (memLbN === 1'b0) physMem[memAddr[7:0]][7:0]  = memData[7:0];
      if (memUbN === 1'b0) physMem[memAddr[7:0]][15:8] = memData[15:8];
    end
  end

  typedef struct {
    bit          rdy, cs, we, oe, ub, lb;
    bit          chkAddr;
    logic [17:0] addr;
    bit          rspV;
    logic [15:0] rspD;
    string       rspTag;
    bit          drv;
    logic [1:0]  lanes;
    logic [15:0] drvD;
    string       tag;
  } expCyc_t;

  typedef struct {
    bit          wr;
    logic [17:0] addr;
    logic [1:0]  be;
    logic [15:0] data;
    int          gap;
    string       tag;
  } req_t;

  expCyc_t expQ[$];
  req_t    reqs[$];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, expv, $time);
    end
  endtask

  function automatic expCyc_t idleCyc(string tag);
    expCyc_t e;
    e.rdy = 1; e.cs = 1; e.we = 1; e.oe = 1; e.ub = 1; e.lb = 1;
    e.chkAddr = 0; e.addr = '0; e.rspV = 0; e.rspD = '0; e.rspTag = "R4";
    e.drv = 0; e.lanes = '0; e.drvD = '0; e.tag = tag;
    return e;
  endfunction

  task automatic addReq(bit wr, logic [17:0] a, logic [1:0] be, logic [15:0] d, int gap, string tag);
    req_t r;
    r.wr = wr; r.addr = a; r.be = be; r.data = d; r.gap = gap; r.tag = tag;
    reqs.push_back(r);
  endtask

  // Expected per-cycle outputs for an accepted request
  task automatic pushExpect(req_t r);
    expCyc_t e;
    logic [15:0] m;
    if (r.be == 2'b00) begin
      if (!r.wr) begin            // R10: zero-lane read answers with zero
        e = idleCyc("R10");
        e.rspV = 1; e.rspD = '0; e.rspTag = "R10";
        expQ.push_back(e);
      end
      return;
    end
    if (!r.wr) begin
      for (int i = 0; i < RD; i++) begin
        e = idleCyc("R3");
        e.rdy = 0; e.cs = 0; e.oe = 0;
        e.lb = !r.be[0]; e.ub = !r.be[1];
        e.chkAddr = 1; e.addr = r.addr;
        expQ.push_back(e);
      end
      m = expMem[r.addr[7:0]];
      e = idleCyc("R5");
      e.rdy = 0; e.rspV = 1; e.rspTag = r.tag;
      e.rspD = {r.be[1] ? m[15:8] : 8'h00, r.be[0] ? m[7:0] : 8'h00};
      expQ.push_back(e);
    end else begin
      for (int i = 0; i < WR + HLD; i++) begin
        e = idleCyc(i < WR ? "R6" : "R7");
        e.rdy = 0; e.cs = 0; e.we = (i >= WR); e.oe = 1;
        e.lb = !r.be[0]; e.ub = !r.be[1];
        e.chkAddr = 1; e.addr = r.addr;
        e.drv = 1; e.lanes = r.be; e.drvD = r.data;
        expQ.push_back(e);
      end
      if (r.be[0]) expMem[r.addr[7:0]][7:0]  = r.data[7:0];
      if (r.be[1]) expMem[r.addr[7:0]][15:8] = r.data[15:8];
    end
  endtask

  task automatic compare(expCyc_t e);
    logic [15:0] busExp;
    chk(e.tag, "reqReady", 32'(reqReady), 32'(e.rdy));
    chk(e.tag, "memCsN",   32'(memCsN),   32'(e.cs));
    chk(e.tag, "memWeN",   32'(memWeN),   32'(e.we));
    chk(e.tag, "memOeN",   32'(memOeN),   32'(e.oe));
    chk(e.tag, "memUbN",   32'(memUbN),   32'(e.ub));
    chk(e.tag, "memLbN",   32'(memLbN),   32'(e.lb));
    if (e.chkAddr) chk(e.tag, "memAddr", 32'(memAddr), 32'(e.addr));
    chk(e.rspV ? e.rspTag : "R4", "rspValid", 32'(rspValid), 32'(e.rspV));
    if (e.rspV) chk(e.rspTag, "rspData", 32'(rspData), 32'(e.rspD));
    if (e.drv) begin
      busExp[7:0]  = e.lanes[0] ? e.drvD[7:0]  : 8'hzz;
      busExp[15:8] = e.lanes[1] ? e.drvD[15:8] : 8'hzz;
      chk(e.tag, "memData", {16'h0, memData}, {16'h0, busExp});
    end else if (e.oe) begin
      chk("R8", "memData idle", {16'h0, memData}, {16'h0, 16'hzzzz});
    end else begin
      if (e.lb) chk("R8", "memData low lane", {24'h0, memData[7:0]},  {24'h0, 8'hzz});
      if (e.ub) chk("R8", "memData high lane", {24'h0, memData[15:8]}, {24'h0, 8'hzz});
    end
  endtask

  initial begin : main
    expCyc_t e;
    req_t    r;
    int      cycle = 0;
    int      tail = 0;
    bit      done = 0;

    for (int i = 0; i < 256; i++) begin
      physMem[i] = 16'(i * 257 + 16'h1357);
      expMem[i]  = physMem[i];
    end
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0;
    reqAddr = '0; reqWdata = '0; reqByteEn = '0;

    // R4 plain read of preset content
    addReq(0, 18'h3_0010, 2'b11, 16'h0, 0, "R4");
    // R6 R7 full write, then read back (write-hold correctness)
    addReq(1, 18'h3_0010, 2'b11, 16'hBEEF, 0, "R6");
    addReq(0, 18'h3_0010, 2'b11, 16'h0, 0, "R7");
    // R9 single-lane writes keep the other byte
    addReq(1, 18'h0_0021, 2'b01, 16'hAB12, 2, "R9");
    addReq(0, 18'h0_0021, 2'b11, 16'h0, 0, "R9");
    addReq(1, 18'h0_0021, 2'b10, 16'h56CD, 0, "R9");
    addReq(0, 18'h0_0021, 2'b11, 16'h0, 1, "R9");
    // R9 single-lane reads return zero on the disabled lane
    addReq(0, 18'h2_0042, 2'b01, 16'h0, 0, "R9");
    addReq(0, 18'h2_0042, 2'b10, 16'h0, 0, "R9");
    // R10 zero-lane write then read: nothing changes
    addReq(1, 18'h0_0021, 2'b00, 16'hFFFF, 0, "R10");
    addReq(0, 18'h0_0021, 2'b11, 16'h0, 0, "R10");
    addReq(0, 18'h1_0077, 2'b00, 16'h0, 0, "R10");
    addReq(0, 18'h1_0078, 2'b00, 16'h0, 0, "R10");
    // R5 read followed at once by a write to the same word
    addReq(0, 18'h1_0050, 2'b11, 16'h0, 0, "R5");
    addReq(1, 18'h1_0050, 2'b11, 16'h7E81, 0, "R5");
    addReq(0, 18'h1_0050, 2'b11, 16'h0, 0, "R5");
    // R2 back-to-back writes, then top address
    addReq(1, 18'h0_0033, 2'b11, 16'h0F0F, 3, "R2");
    addReq(1, 18'h0_0034, 2'b10, 16'hC3A5, 0, "R2");
    addReq(1, 18'h3_FFFF, 2'b11, 16'h9A9A, 0, "R6");
    addReq(0, 18'h0_0034, 2'b11, 16'h0, 0, "R9");
    addReq(0, 18'h3_FFFF, 2'b11, 16'h0, 0, "R4");

    // R1 reset state
    repeat (3) begin
      @(negedge clk);
      compare(idleCyc("R1"));
    end
    rstN = 1'b1;

    while (!done) begin
      @(negedge clk);
      cycle++;
      e = (expQ.size() > 0) ? expQ.pop_front() : idleCyc("R1");
      compare(e);
      if (reqs.size() > 0) begin
        if (reqs[0].gap > 0) begin
          reqs[0].gap = reqs[0].gap - 1;
          reqValid = 1'b0;
        end else begin
          r = reqs[0];
          reqValid = 1'b1; reqWrite = r.wr; reqAddr = r.addr;
          reqWdata = r.data; reqByteEn = r.be;
          if (e.rdy) begin   // R2: taken at the coming edge
            pushExpect(r);
            void'(reqs.pop_front());
          end
        end
      end else begin
        reqValid = 1'b0;
        if (expQ.size() == 0) tail++;
        if (tail > 4) done = 1;
      end
      if (cycle > 5000) begin
        errors++;
        $display("FAIL watchdog expired actual=%0d expected<=5000", cycle);
        done = 1;
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule